// File: doc/BRIEF.md
# ADC Conversion Flag Clearing Controller

This block is the digital status and control logic that sits beside a multi-channel analog-to-digital converter. It keeps a result register and a conversion-complete flag for each of eight channels, plus one flag that says the whole sequence has finished. Software reaches it through a small register bus with an address, a read strobe, a write strobe and a data byte. A conversion engine reports each finished channel with a strobe, a channel index and the result byte.

Flags clear on a read-history protocol. In normal mode software must read the flag status register while a channel's flag is set, and then read that channel's result, before the flag drops. In fast mode a result access alone clears the flag, and the first result read also clears the sequence flag. The block also gates the engine. It keeps conversions stopped until the power enable has been on for a recovery time. Dropping the power enable aborts the running sequence. A stop-in-wait option halts and powers down the converter while the processor is in wait mode.

Top module: `adc_flag_ctrl`

## Requirements
- R1: After reset all channel flags, the sequence flag, `conv_go` and `pwr_on` are 0, and the control, mask and result registers read 0.
- R2: Address 0 is control: bit 0 is the power enable, bit 1 selects fast clear and bit 2 is stop-in-wait. Address 2 is the channel mask. Address 3 reads the sequence flag in bit 7 and "sequence running" in bit 6. Address 4 reads the channel flags, with bit i for channel i. Addresses 8 to 15 read the results of channels 0 to 7.
- R3: `conv_go` is not asserted until REC_CYC cycles (default 16) after the clock edge that turns the converter on. Each new power-on restarts this count.
- R4: When the power enable is cleared, `conv_go` falls in the same cycle and the pending sequence is dropped. The sequence flag does not set for it, and later completions are ignored.
- R5: While stop-in-wait is 1 and `mcu_wait` is high, `pwr_on` and `conv_go` are low and the sequence is aborted. When stop-in-wait is 0, wait has no effect.
- R6: A completion is accepted only while `conv_go` is high and the channel is still pending. It stores the result and sets that channel's flag. Any other completion changes nothing.
- R7: In normal mode, reading a channel's result clears its flag only if a flag-status read was made earlier while that flag was set.
- R8: A flag-status read made while a flag was clear does not arm it. A new completion on a channel, or a sequence start, disarms that channel.
- R9: In fast mode, any result read clears that channel's flag, with no status read needed.
- R10: A write to address 1 (restart with the stored mask) or address 2 (load the mask and start) clears the sequence flag. The sequence flag sets when the last pending channel completes.
- R11: In fast mode, any result read also clears the sequence flag. In normal mode, result reads leave it unchanged.
- R12: When a completion and a clearing read hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the same cycle as the read strobe, 0 when not reading |
| eng_done | input | 1 | Engine completion strobe |
| eng_chan | input | 3 | Channel that completed |
| eng_data | input | 8 | Result byte of that channel |
| mcu_wait | input | 1 | Processor is in wait mode |
| ccf | output | 8 | Per-channel conversion-complete flags |
| scf | output | 1 | Sequence-complete flag |
| conv_go | output | 1 | Engine may convert |
| pwr_on | output | 1 | Converter is powered |

## Verification
A stale armed bit shows up at the first result read: a flag drops in normal mode without a status read in the same flag lifetime. A missing armed bit shows up the same way, because a flag survives a proper status-then-result pair. Both are visible on `ccf` one cycle after the read. A recovery counter that is off by one moves the first `conv_go` cycle. An abort that fails to clear the pending mask shows up as a sequence flag that sets, or a completion that is accepted, after power-down or wait.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  localparam int ADDR_W   = 4;
  localparam int RES_BASE = 8;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL    = 4'h0;
  localparam addr_t A_RESTART = 4'h1;
  localparam addr_t A_MASK    = 4'h2;
  localparam addr_t A_SEQSTAT = 4'h3;
  localparam addr_t A_CCFSTAT = 4'h4;

  typedef struct packed {
    logic stop_wait;
    logic fast_clr;
    logic pwr_en;
  } ctrl_t;
endpackage

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl #(
  parameter int REC_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic stop_wait,
  input  logic mcu_wait,
  output logic pwr_on,
  output logic ready
);
  localparam int CW = (REC_CYC < 1) ? 1 : $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(REC_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // powered unless disabled or halted by wait
  assign pwr_on = pwr_en & ~(stop_wait & mcu_wait);
  assign ready  = pwr_on & (cnt_q == LIMIT);
  assign cnt_en = ~pwr_on | (cnt_q != LIMIT);

  always_comb begin
    if (!pwr_on) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_tracker.sv
module adc_seq_tracker #(
  parameter int N_CH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_CH-1:0]         start_mask,
  input  logic                    pwr_on,
  input  logic                    ready,
  input  logic                    fast_clr,
  input  logic                    any_res_rd,
  input  logic                    eng_done,
  input  logic [$clog2(N_CH)-1:0] eng_chan,
  output logic                    active,
  output logic                    conv_go,
  output logic [N_CH-1:0]         ch_set,
  output logic                    scf
);
  logic [N_CH-1:0] pend_q, pend_d, chan_oh, pend_left;
  logic            accept, scf_set, scf_clr, scf_d;

  assign active    = |pend_q;
  assign conv_go   = active & ready;
  assign chan_oh   = N_CH'(1) << eng_chan;
  assign accept    = eng_done & conv_go & |(pend_q & chan_oh);
  assign ch_set    = accept ? chan_oh : '0;
  assign pend_left = pend_q & ~chan_oh;
  assign scf_set   = accept & ~start & (pend_left == '0);
  assign scf_clr   = start | (fast_clr & any_res_rd);

  always_comb begin
    if (!pwr_on)     pend_d = '0;
    else if (start)  pend_d = start_mask;
    else if (accept) pend_d = pend_left;
    else             pend_d = pend_q;
  end

  always_comb begin
    if (scf_set)      scf_d = 1'b1;
    else if (scf_clr) scf_d = 1'b0;
    else              scf_d = scf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      scf    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      scf    <= scf_d;
    end
  end
endmodule

// File: rtl/adc_flag_bank.sv
module adc_flag_bank #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fast_clr,
  input  logic            stat_rd,
  input  logic            start,
  input  logic [N_CH-1:0] res_rd,
  input  logic [N_CH-1:0] ch_set,
  output logic [N_CH-1:0] ccf
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic seen_q, seen_d, ccf_d, clr;

    assign clr = res_rd[i] & ccf[i] & (fast_clr | seen_q);

    always_comb begin
      if (ch_set[i])      ccf_d = 1'b1;
      else if (clr)       ccf_d = 1'b0;
      else                ccf_d = ccf[i];
    end

    always_comb begin
      if (ch_set[i] | clr | start) seen_d = 1'b0;
      else if (stat_rd & ccf[i])   seen_d = 1'b1;
      else                         seen_d = seen_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ccf[i] <= 1'b0;
        seen_q <= 1'b0;
      end else begin
        ccf[i] <= ccf_d;
        seen_q <= seen_d;
      end
    end
  end
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
  import adc_flag_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic                    eng_done,
  input  logic [$clog2(N_CH)-1:0] eng_chan,
  input  logic [DATA_W-1:0]       eng_data,
  input  logic                    mcu_wait,
  output logic [N_CH-1:0]         ccf,
  output logic                    scf,
  output logic                    conv_go,
  output logic                    pwr_on
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t           ctrl_q;
  logic [N_CH-1:0] mask_q, start_mask, res_rd, ch_set;
  logic            ctrl_we, mask_we, start, stat_rd, ready, active;
  logic            fast_clr_q, stop_wait_q;
  logic [DATA_W-1:0] res_q [N_CH];

  assign ctrl_we     = wr_en & (addr == A_CTRL);
  assign mask_we     = wr_en & (addr == A_MASK);
  assign start       = mask_we | (wr_en & (addr == A_RESTART));
  assign start_mask  = mask_we ? wdata[N_CH-1:0] : mask_q;
  assign stat_rd     = rd_en & (addr == A_CCFSTAT);
  assign fast_clr_q  = ctrl_q.fast_clr;
  assign stop_wait_q = ctrl_q.stop_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata[N_CH-1:0];
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_res
    assign res_rd[i] = rd_en & (addr == ADDR_W'(RES_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         res_q[i] <= '0;
      else if (ch_set[i]) res_q[i] <= eng_data;
    end
  end

  adc_power_ctrl #(.REC_CYC(REC_CYC)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_en   (ctrl_q.pwr_en),
    .stop_wait(ctrl_q.stop_wait),
    .mcu_wait (mcu_wait),
    .pwr_on   (pwr_on),
    .ready    (ready)
  );

  adc_seq_tracker #(.N_CH(N_CH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_mask(start_mask),
    .pwr_on    (pwr_on),
    .ready     (ready),
    .fast_clr  (ctrl_q.fast_clr),
    .any_res_rd(|res_rd),
    .eng_done  (eng_done),
    .eng_chan  (eng_chan),
    .active    (active),
    .conv_go   (conv_go),
    .ch_set    (ch_set),
    .scf       (scf)
  );

  adc_flag_bank #(.N_CH(N_CH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .fast_clr(ctrl_q.fast_clr),
    .stat_rd (stat_rd),
    .start   (start),
    .res_rd  (res_rd),
    .ch_set  (ch_set),
    .ccf     (ccf)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL:    rdata = DATA_W'(ctrl_q);
        A_MASK:    rdata = DATA_W'(mask_q);
        A_SEQSTAT: rdata = DATA_W'({scf, active}) << (DATA_W - 2);
        A_CCFSTAT: rdata = DATA_W'(ccf);
        default: begin
          for (int k = 0; k < N_CH; k++)
            if (res_rd[k]) rdata = res_q[k];
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_flag_ctrl_chk.sv
module adc_flag_ctrl_chk #(
  parameter int N_CH    = 8,
  parameter int REC_CYC = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      addr,
  input logic            rd_en,
  input logic            wr_en,
  input logic            eng_done,
  input logic            mcu_wait,
  input logic [N_CH-1:0] ccf,
  input logic            scf,
  input logic            conv_go,
  input logic            pwr_on,
  input logic            fast_clr,
  input logic            stop_wait
);
  AST_REC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (REC_CYC > 1) && $rose(pwr_on) |=> !conv_go); // R3
  AST_NO_GO_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> !conv_go); // R4
  AST_WAIT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wait && mcu_wait |-> !conv_go); // R5
  AST_CCF_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    |(ccf & ~$past(ccf)) |-> $past(eng_done && conv_go)); // R6
  AST_CCF_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(ccf) & ~ccf) |-> $past(rd_en && addr[3])); // R7
  AST_SCF_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scf) |-> $past(eng_done && conv_go)); // R10
  AST_SCF_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scf) |-> $past(wr_en && (addr == 4'h1 || addr == 4'h2))
                   || $past(rd_en && addr[3] && fast_clr)); // R11
endmodule

bind adc_flag_ctrl adc_flag_ctrl_chk #(.N_CH(N_CH), .REC_CYC(REC_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .eng_done (eng_done),
  .mcu_wait (mcu_wait),
  .ccf      (ccf),
  .scf      (scf),
  .conv_go  (conv_go),
  .pwr_on   (pwr_on),
  .fast_clr (fast_clr_q),
  .stop_wait(stop_wait_q)
);

// File: tb/adc_flag_ctrl_tb.sv
module adc_flag_ctrl_tb;
  localparam int REC = 16;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_DONE = 2'd3;
  localparam int NV = 28;
  // {op, addr, data, expected, requirement}
  localparam logic [25:0] VEC [NV] = '{
    {OP_WR,   4'h0, 8'h01, 8'h00, 4'd3},  // power on
    {OP_WR,   4'h2, 8'h05, 8'h00, 4'd10}, // start ch0+ch2
    {OP_IDLE, 4'h0, 8'd16, 8'h00, 4'd3},
    {OP_DONE, 4'h0, 8'h3A, 8'h00, 4'd6},
    {OP_RD,   4'h4, 8'h00, 8'h01, 4'd7},  // R7 arms ch0
    {OP_DONE, 4'h2, 8'hC4, 8'h00, 4'd6},
    {OP_RD,   4'h3, 8'h00, 8'h80, 4'd10}, // R10 done, idle
    {OP_RD,   4'hA, 8'h00, 8'hC4, 4'd8},  // R8 ch2 not armed
    {OP_RD,   4'h4, 8'h00, 8'h05, 4'd8},
    {OP_RD,   4'h8, 8'h00, 8'h3A, 4'd7},
    {OP_RD,   4'h4, 8'h00, 8'h04, 4'd7},
    {OP_RD,   4'hA, 8'h00, 8'hC4, 4'd7},
    {OP_RD,   4'h4, 8'h00, 8'h00, 4'd7},
    {OP_RD,   4'h3, 8'h00, 8'h80, 4'd11}, // R11 normal keeps scf
    {OP_WR,   4'h1, 8'h00, 8'h00, 4'd10},
    {OP_RD,   4'h3, 8'h00, 8'h40, 4'd10},
    {OP_WR,   4'h0, 8'h03, 8'h00, 4'd9},  // fast mode
    {OP_DONE, 4'h0, 8'h11, 8'h00, 4'd6},
    {OP_DONE, 4'h2, 8'h22, 8'h00, 4'd6},
    {OP_RD,   4'hA, 8'h00, 8'h22, 4'd9},
    {OP_RD,   4'h4, 8'h00, 8'h01, 4'd9},  // R9
    {OP_RD,   4'h3, 8'h00, 8'h00, 4'd11}, // R11
    {OP_DONE, 4'h1, 8'h55, 8'h00, 4'd6},  // not pending
    {OP_RD,   4'h9, 8'h00, 8'h00, 4'd6},  // R6 ignored
    {OP_RD,   4'h4, 8'h00, 8'h01, 4'd6},
    {OP_RD,   4'h8, 8'h00, 8'h11, 4'd9},
    {OP_RD,   4'h4, 8'h00, 8'h00, 4'd9},
    {OP_RD,   4'h0, 8'h00, 8'h03, 4'd2}   // R2
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, eng_done = 1'b0, mcu_wait = 1'b0;
  logic [7:0] wdata = '0, eng_data = '0, rdata, ccf;
  logic [2:0] eng_chan = '0;
  logic       scf, conv_go, pwr_on;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_flag_ctrl #(.REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .eng_done(eng_done), .eng_chan(eng_chan),
    .eng_data(eng_data), .mcu_wait(mcu_wait), .ccf(ccf), .scf(scf),
    .conv_go(conv_go), .pwr_on(pwr_on)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 chk(rdata == e, req, rdata, e);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic done(input logic [2:0] c, input logic [7:0] d);
    @(negedge clk); eng_done = 1'b1; eng_chan = c; eng_data = d;
    @(posedge clk); #1 eng_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first_go;
    // R1 reset state
    repeat (3) @(posedge clk);
    #1 chk({ccf, scf, conv_go, pwr_on} == '0, "R1", {ccf, scf, conv_go, pwr_on}, 0);
    @(negedge clk) rst_n = 1'b1;
    rd(4'h0, 8'h00, "R1");
    rd(4'hF, 8'h00, "R1");

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][3:0]);
      case (VEC[i][25:24])
        OP_WR:   wr(VEC[i][23:20], VEC[i][19:12]);
        OP_RD:   rd(VEC[i][23:20], VEC[i][11:4], tag);
        OP_DONE: done(VEC[i][22:20], VEC[i][19:12]);
        default: idle(int'(VEC[i][19:12]));
      endcase
    end
    rd(4'h2, 8'h05, "R2");

    // R3 recovery count from power-on edge
    wr(4'h0, 8'h00);
    wr(4'h0, 8'h01);
    wr(4'h2, 8'h80);
    first_go = 0;
    for (int n = 2; n <= 20; n++) begin
      @(posedge clk); #1;
      if (conv_go && first_go == 0) first_go = n;
    end
    chk(first_go == REC, "R3", first_go, REC);

    // R12 collision: set wins
    done(3'd7, 8'h77);
    wr(4'h1, 8'h00);
    rd(4'h4, 8'h80, "R12");
    @(negedge clk); eng_done = 1'b1; eng_chan = 3'd7; eng_data = 8'h78;
    rd_en = 1'b1; addr = 4'hF;
    @(posedge clk); #1 eng_done = 1'b0; rd_en = 1'b0;
    chk(ccf[7] == 1'b1, "R12", ccf[7], 1);
    rd(4'hF, 8'h78, "R12");
    #1 chk(ccf[7] == 1'b1, "R8", ccf[7], 1);  // disarmed by new set
    rd(4'h4, 8'h80, "R8");
    rd(4'hF, 8'h78, "R7");
    #1 chk(ccf == 8'h00, "R7", ccf, 0);

    // R4 abort on power-down
    wr(4'h2, 8'h03);
    done(3'd0, 8'h10);
    wr(4'h0, 8'h00);
    #1 chk(conv_go == 1'b0, "R4", conv_go, 0);
    done(3'd1, 8'h20);
    chk(ccf == 8'h01, "R4", ccf, 8'h01);
    rd(4'h3, 8'h00, "R4");

    // R5 stop in wait
    wr(4'h0, 8'h05);
    idle(REC + 2);
    wr(4'h2, 8'h01);
    chk(conv_go == 1'b1, "R5", conv_go, 1);
    @(negedge clk); mcu_wait = 1'b1;
    #1 chk({pwr_on, conv_go} == 2'b00, "R5", {pwr_on, conv_go}, 0);
    idle(2);
    @(negedge clk); mcu_wait = 1'b0;
    rd(4'h3, 8'h00, "R5");
    wr(4'h0, 8'h01);
    idle(REC + 2);
    wr(4'h2, 8'h01);
    @(negedge clk); mcu_wait = 1'b1;
    #1 chk(conv_go == 1'b1, "R5", conv_go, 1);
    done(3'd0, 8'h99);
    rd(4'h8, 8'h99, "R5");
    rd(4'h3, 8'h80, "R10");
    mcu_wait = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule